// File: doc/BRIEF.md
# Full-Bridge Gate Decoder with Protection Latch

This block turns two logic-level modulation inputs into the four gate enables of one H-bridge: a high-side and a low-side switch on each of two legs. Each leg is either driven high, driven low or left off. Every change from one driven level to the other passes through a programmable stretch of clock cycles with both switches of that leg off.

An enable input, a power-down input and three protection sources stand between the modulation inputs and the gates. The protection sources are an overcurrent flag, an 8-bit junction temperature in degrees Celsius and an undervoltage flag. Overcurrent and over-temperature turn the switches off in the same cycle. They are then held as a latched fault, which only a high-low-high sequence on the enable input removes. Undervoltage only blocks the gates while it lasts. The fault and thermal-warning status outputs are active low, in the manner of open-drain pins with pull-ups.

A PWM modulator drives the block directly. Supervisory logic uses the enable input to park the bridge in high impedance and to acknowledge faults.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While `drive_en` is 0, all four gate enables are 0 in that same cycle, whatever the modulation inputs.
- R2: With `drive_en`=1 and no block condition, `{mod_a,mod_b}` selects the gates as follows. 00 gives `gate_al`,`gate_bl` (both low sides, a braking state). 01 gives `gate_al`,`gate_bh`. 10 gives `gate_ah`,`gate_bl`. 11 gives `gate_ah`,`gate_bh`. Outputs are written {ah,al,bh,bl}.
- R3: A leg moving between high and low keeps both of its switches off for exactly `DEAD_CYC` cycles (default 2). A leg that has sat off for at least `DEAD_CYC` cycles turns on at the first clock edge after it is asked to.
- R4: No leg ever has its high-side and low-side enable at 1 together.
- R5: `oc_flag`=1 with `pwr_on`=1 turns all gates off and drives `fault_n` to 0 in the same cycle. The fault stays latched after the flag drops.
- R6: A latched fault clears only on a high-then-low-then-high sequence of `drive_en`. A rise of `drive_en` that does not follow a fall seen while latched leaves the fault set. After a clear, switching resumes.
- R7: If the fault condition is still present when `drive_en` returns high, the fault stays latched.
- R8: Thermal shutdown trips when `temp_c` >= 150 and remains a fault condition until `temp_c` <= 125. A reading of 149 after release does not trip.
- R9: `twarn_n` is 0 exactly when `temp_c` >= 130.
- R10: `uv_flag`=1 turns all gates off while it lasts, leaves `fault_n` at 1, and switching resumes on its own once it clears.
- R11: `pwr_on`=0 turns all gates off and clears a latched fault, so no enable sequence is needed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drive_en | input | 1 | 0 = bridge high impedance; a high-low-high sequence acknowledges a fault |
| pwr_on | input | 1 | 0 = power down: gates off, fault latch cleared |
| mod_a | input | 1 | Modulation input of leg A |
| mod_b | input | 1 | Modulation input of leg B |
| oc_flag | input | 1 | Overcurrent detected |
| temp_c | input | 8 | Junction temperature, unsigned, degrees Celsius |
| uv_flag | input | 1 | Supply below undervoltage threshold |
| gate_ah | output | 1 | High-side enable, leg A |
| gate_al | output | 1 | Low-side enable, leg A |
| gate_bh | output | 1 | High-side enable, leg B |
| gate_bl | output | 1 | Low-side enable, leg B |
| fault_n | output | 1 | 0 = fault active or latched |
| twarn_n | output | 1 | 0 = thermal warning |

## Verification
The decode is tried with all four input codes while enabled and with several codes while disabled. This tells a wrong leg mapping apart from a missing high-impedance override. The sequence of codes also forces high-to-low, low-to-high and both-legs-changing transitions, and the bench counts the off cycles on one leg to separate a dead time that is too short from one that is too long. Fault clearing is tried four ways: a lone rising enable, a full sequence with the temperature still above release, a full sequence just above the release point, and a full sequence at the release point. Only the last may clear, which separates hysteresis from a plain threshold. Undervoltage and power-down are each followed by a return to switching with no enable sequence, which tells the auto-recovering paths apart from the latched one.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  // Drive state of one bridge leg; both-on is not encodable.
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_state_e;

  localparam int NLEG = 2;

endpackage

// File: rtl/bgc_decode.sv
module bgc_decode
  import bgc_pkg::*;
(
  input  logic       block,
  input  logic       mod_a,
  input  logic       mod_b,
  output leg_state_e want_a,
  output leg_state_e want_b
);

  always_comb begin
    want_a = LEG_OFF;
    want_b = LEG_OFF;
    if (!block) begin
      unique case ({mod_a, mod_b})
        2'b00: begin want_a = LEG_LO; want_b = LEG_LO; end
        2'b01: begin want_a = LEG_LO; want_b = LEG_HI; end
        2'b10: begin want_a = LEG_HI; want_b = LEG_LO; end
        default: begin want_a = LEG_HI; want_b = LEG_HI; end
      endcase
    end
  end

endmodule

// File: rtl/bgc_leg.sv
module bgc_leg
  import bgc_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  leg_state_e want,
  output leg_state_e state
);

  localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DEAD_CYC - 1);

  leg_state_e       cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    cur_d = cur_q;
    cnt_d = cnt_q;
    if (want == LEG_OFF) begin
      cur_d = LEG_OFF;
      if (cur_q != LEG_OFF)   cnt_d = RELOAD;
      else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end else if (want != cur_q) begin
      if (cur_q != LEG_OFF) begin
        cur_d = LEG_OFF;
        cnt_d = RELOAD;
      end else if (cnt_q == '0) begin
        cur_d = want;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    upd = (cur_d != cur_q) || (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LEG_OFF;
      cnt_q <= '0;
    end else if (upd) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = cur_q;

endmodule

// File: rtl/bgc_protect.sv
module bgc_protect #(
  parameter int TEMP_W  = 8,
  parameter int WARN_C  = 130,
  parameter int TRIP_C  = 150,
  parameter int CLEAR_C = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              drive_en,
  input  logic              oc_flag,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              block,
  output logic              fault_n,
  output logic              twarn_n
);

  localparam logic [TEMP_W-1:0] WARN_T  = TEMP_W'(WARN_C);
  localparam logic [TEMP_W-1:0] TRIP_T  = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] CLEAR_T = TEMP_W'(CLEAR_C);

  logic hot_q, hot_d;
  logic latch_q, latch_d;
  logic arm_q, arm_d;
  logic en_q;
  logic detect, en_fall, en_rise;

  always_comb begin
    hot_d   = (temp_c >= TRIP_T) || (hot_q && (temp_c > CLEAR_T));
    detect  = pwr_on && (oc_flag || hot_d);
    en_fall = en_q && !drive_en;
    en_rise = !en_q && drive_en;

    arm_d = arm_q;
    if (!pwr_on || en_rise)      arm_d = 1'b0;
    else if (latch_q && en_fall) arm_d = 1'b1;

    latch_d = latch_q;
    if (!pwr_on)                 latch_d = 1'b0;
    else if (detect)             latch_d = 1'b1;
    else if (arm_q && en_rise)   latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q   <= 1'b0;
      latch_q <= 1'b0;
      arm_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      hot_q   <= hot_d;
      latch_q <= latch_d;
      arm_q   <= arm_d;
      en_q    <= drive_en;
    end
  end

  assign block   = latch_q || detect;
  assign fault_n = !block;
  assign twarn_n = !(temp_c >= WARN_T);

endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int TEMP_W   = 8,
  parameter int WARN_C   = 130,
  parameter int TRIP_C   = 150,
  parameter int CLEAR_C  = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_en,
  input  logic              pwr_on,
  input  logic              mod_a,
  input  logic              mod_b,
  input  logic              oc_flag,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic              uv_flag,
  output logic              gate_ah,
  output logic              gate_al,
  output logic              gate_bh,
  output logic              gate_bl,
  output logic              fault_n,
  output logic              twarn_n
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic prot_block, kill;

  bgc_protect #(
    .TEMP_W (TEMP_W),
    .WARN_C (WARN_C),
    .TRIP_C (TRIP_C),
    .CLEAR_C(CLEAR_C)
  ) u_prot (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pwr_on  (pwr_on),
    .drive_en(drive_en),
    .oc_flag (oc_flag),
    .temp_c  (temp_c),
    .block   (prot_block),
    .fault_n (fault_n),
    .twarn_n (twarn_n)
  );

  assign kill = !pwr_on || !drive_en || uv_flag || prot_block;

  leg_state_e leg_want [NLEG];
  leg_state_e leg_st   [NLEG];
  logic [NLEG-1:0] hs_en, ls_en;

  bgc_decode u_dec (
    .block (kill),
    .mod_a (mod_a),
    .mod_b (mod_b),
    .want_a(leg_want[0]),
    .want_b(leg_want[1])
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    bgc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .want (leg_want[g]),
      .state(leg_st[g])
    );
    assign hs_en[g] = (leg_st[g] == LEG_HI) && !kill;
    assign ls_en[g] = (leg_st[g] == LEG_LO) && !kill;
  end

  assign gate_ah = hs_en[0];
  assign gate_al = ls_en[0];
  assign gate_bh = hs_en[1];
  assign gate_bl = ls_en[1];

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int TEMP_W = 8,
  parameter int WARN_C = 130,
  parameter int TRIP_C = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive_en,
  input logic              pwr_on,
  input logic              oc_flag,
  input logic [TEMP_W-1:0] temp_c,
  input logic              uv_flag,
  input logic              gate_ah,
  input logic              gate_al,
  input logic              gate_bh,
  input logic              gate_bl,
  input logic              fault_n,
  input logic              twarn_n
);

  logic any_gate;
  assign any_gate = gate_ah | gate_al | gate_bh | gate_bl;

  p_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> !any_gate);

  p_excl_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ah && gate_al));

  p_excl_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_bh && gate_bl));

  p_dead_al_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_al) |-> !$past(gate_ah));

  p_dead_ah_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ah) |-> !$past(gate_al));

  p_dead_bl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_bl) |-> !$past(gate_bh));

  p_dead_bh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_bh) |-> !$past(gate_bl));

  p_oc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && pwr_on) |-> (!fault_n && !any_gate));

  p_clear_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_n) && $past(pwr_on)) |-> ($past(drive_en) && !$past(drive_en, 2)));

  p_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && temp_c >= TEMP_W'(TRIP_C)) |-> !fault_n);

  p_warn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_c >= TEMP_W'(WARN_C)) |-> !twarn_n);

  p_uv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> !any_gate);

  p_pdn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> !any_gate);

endmodule

bind bridge_gate_ctrl bgc_checker #(
  .TEMP_W(TEMP_W),
  .WARN_C(WARN_C),
  .TRIP_C(TRIP_C)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .drive_en(drive_en),
  .pwr_on  (pwr_on),
  .oc_flag (oc_flag),
  .temp_c  (temp_c),
  .uv_flag (uv_flag),
  .gate_ah (gate_ah),
  .gate_al (gate_al),
  .gate_bh (gate_bh),
  .gate_bl (gate_bl),
  .fault_n (fault_n),
  .twarn_n (twarn_n)
);

// File: tb/tb_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module tb_bridge_gate_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       drive_en, pwr_on, mod_a, mod_b, oc_flag, uv_flag;
  logic [7:0] temp_c;
  logic       gate_ah, gate_al, gate_bh, gate_bl, fault_n, twarn_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bridge_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .pwr_on(pwr_on),
    .mod_a(mod_a), .mod_b(mod_b), .oc_flag(oc_flag), .temp_c(temp_c),
    .uv_flag(uv_flag), .gate_ah(gate_ah), .gate_al(gate_al),
    .gate_bh(gate_bh), .gate_bl(gate_bl), .fault_n(fault_n), .twarn_n(twarn_n)
  );

  // {drive_en, mod_a, mod_b, expected ah, al, bh, bl}
  localparam logic [6:0] VEC [8] = '{
    7'b100_0101, 7'b110_1001, 7'b101_0110, 7'b111_1010,
    7'b010_0000, 7'b011_0000, 7'b100_0101, 7'b000_0000
  };

  function automatic logic [3:0] gates();
    return {gate_ah, gate_al, gate_bh, gate_bl};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic en_seq();
    cyc(1); drive_en = 1'b0;
    cyc(2); drive_en = 1'b1;
    cyc(2);
  endtask

  task automatic oc_pulse();
    cyc(1); oc_flag = 1'b1;
    cyc(1); oc_flag = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; drive_en = 1'b0; pwr_on = 1'b1; mod_a = 1'b0; mod_b = 1'b0;
    oc_flag = 1'b0; uv_flag = 1'b0; temp_c = 8'd40;
    cyc(3); rst_n = 1'b1; cyc(4);
    @(negedge clk);
    chk("R1 reset gates", gates(), 4'b0000);
    chk("R5 reset fault_n", fault_n, 1'b1);
    chk("R9 reset twarn_n", twarn_n, 1'b1);

    // Table walk: decode and high impedance
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      {drive_en, mod_a, mod_b} = VEC[i][6:4];
      cyc(5);
      @(negedge clk);
      chk(VEC[i][6] ? "R2 decode" : "R1 hiz", gates(), VEC[i][3:0]);
    end

    // R3: dead time high -> low on leg A
    cyc(1); drive_en = 1'b1; mod_a = 1'b1; mod_b = 1'b0;
    cyc(5);
    mod_a = 1'b0;
    @(negedge clk); chk("R3 before edge", gates(), 4'b1001);
    @(negedge clk); chk("R3 dead cycle 1", gates(), 4'b0001);
    @(negedge clk); chk("R3 dead cycle 2", gates(), 4'b0001);
    @(negedge clk); chk("R3 low on", gates(), 4'b0101);
    // low -> high
    cyc(1); mod_a = 1'b1;
    @(negedge clk); chk("R3 before edge lh", gates(), 4'b0101);
    @(negedge clk); chk("R3 dead lh 1", gates(), 4'b0001);
    @(negedge clk); chk("R3 dead lh 2", gates(), 4'b0001);
    @(negedge clk); chk("R3 high on", gates(), 4'b1001);

    // R1: same-cycle high impedance
    cyc(1); drive_en = 1'b0;
    @(negedge clk); chk("R1 immediate off", gates(), 4'b0000);
    cyc(1); drive_en = 1'b1; cyc(4);

    // R5: overcurrent, immediate and latched
    oc_flag = 1'b1;
    @(negedge clk);
    chk("R5 gates off", gates(), 4'b0000);
    chk("R5 fault_n low", fault_n, 1'b0);
    cyc(1); oc_flag = 1'b0; cyc(4);
    @(negedge clk);
    chk("R5 latched fault", fault_n, 1'b0);
    chk("R5 latched gates", gates(), 4'b0000);

    // R6: full sequence clears
    en_seq();
    @(negedge clk); chk("R6 cleared", fault_n, 1'b1);
    cyc(3); @(negedge clk); chk("R6 resume", gates(), 4'b1001);

    // R6: rise without a fall seen while latched does not clear
    cyc(1); drive_en = 1'b0;
    oc_pulse();
    cyc(2); drive_en = 1'b1; cyc(3);
    @(negedge clk); chk("R6 lone rise", fault_n, 1'b0);
    en_seq();
    @(negedge clk); chk("R6 clear after lone rise", fault_n, 1'b1);

    // R8 / R7: thermal trip and hysteresis
    cyc(3); temp_c = 8'd150;
    @(negedge clk);
    chk("R8 trip at 150", fault_n, 1'b0);
    chk("R9 warn when hot", twarn_n, 1'b0);
    cyc(1); temp_c = 8'd140; cyc(2);
    en_seq();
    @(negedge clk); chk("R7 condition present", fault_n, 1'b0);
    temp_c = 8'd126; cyc(2);
    en_seq();
    @(negedge clk); chk("R8 above release", fault_n, 1'b0);
    temp_c = 8'd125; cyc(2);
    en_seq();
    @(negedge clk); chk("R8 released at 125", fault_n, 1'b1);
    cyc(1); temp_c = 8'd149; cyc(3);
    @(negedge clk); chk("R8 no trip at 149", fault_n, 1'b1);

    // R9: warning threshold
    cyc(1); temp_c = 8'd129;
    @(negedge clk); chk("R9 129 no warn", twarn_n, 1'b1);
    cyc(1); temp_c = 8'd130;
    @(negedge clk); chk("R9 130 warn", twarn_n, 1'b0);
    cyc(1); temp_c = 8'd40; cyc(4);

    // R10: undervoltage, no latch
    @(negedge clk); chk("R10 running", gates(), 4'b1001);
    cyc(1); uv_flag = 1'b1;
    @(negedge clk);
    chk("R10 gates off", gates(), 4'b0000);
    chk("R10 no fault", fault_n, 1'b1);
    cyc(3); uv_flag = 1'b0; cyc(4);
    @(negedge clk); chk("R10 recovered", gates(), 4'b1001);

    // R11: power-down clears the latch
    oc_pulse();
    cyc(1); @(negedge clk); chk("R11 fault set", fault_n, 1'b0);
    cyc(1); pwr_on = 1'b0;
    @(negedge clk); chk("R11 gates off", gates(), 4'b0000);
    cyc(2); pwr_on = 1'b1; cyc(4);
    @(negedge clk);
    chk("R11 latch cleared", fault_n, 1'b1);
    chk("R11 resume", gates(), 4'b1001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule